// File: doc/BRIEF.md
# Four-Entry Nibble Register File

This block stores four 4-bit words and offers one write port and one read port. A write puts the data input into the word chosen by a 2-bit write index. It happens on the falling edge of the clock, and only while the write enable is high. The read port is purely combinational: the 2-bit read index selects which stored word drives the data output, with no clock involved.

Each word is a row of single-bit storage cells, and each cell has a load enable. The write index goes through a one-hot decoder that is gated by the write enable. As a result, on any falling edge at most one word has its cell enables raised. An active-high synchronous reset, sampled on the falling edge, clears every word to zero.

Top module: `quad_regfile`

## Requirements
- R1: The file holds four words of 4 bits each. Read index value n (0 to 3) selects word n, and write index value n selects word n.
- R2: On a falling clock edge with wr_en high and rst low, the word addressed by wr_idx takes the value of wr_data.
- R3: On a falling clock edge with wr_en low and rst low, all four words keep their values, whatever wr_idx and wr_data are.
- R4: A write changes only the word addressed by wr_idx. The other three words keep their values.
- R5: rd_data always equals the word addressed by rd_idx. It follows a change of rd_idx with no clock edge.
- R6: A rising clock edge stores nothing. A read of the word being written shows the old value until the falling edge and the new value after it.
- R7: When rst is high at a falling clock edge, all four words become 0. Reset takes precedence over a write in the same cycle.
- R8: When the same word is written on consecutive falling edges, it holds the data from the most recent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Synchronous active-high clear, sampled on the falling edge |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 2 | Index of the word to write |
| wr_data | input | 4 | Data to store |
| rd_idx | input | 2 | Index of the word to read |
| rd_data | output | 4 | Contents of the word selected by rd_idx |

## Verification
The bench reads the addressed word just after the rising edge, while a write is pending. A design that captures on the wrong edge shows the new value there too early. Cycles with the enable low carry different data and indices, which catches a decoder that ignores the enable. After every edge, all four words are read back, so a write that spills into a neighbouring word or lands at a swapped index is exposed. Back-to-back writes to one word check that the last write wins, and a reset asserted together with a write checks that clearing takes priority.

// File: rtl/qrf_pkg.sv
package qrf_pkg;
    // State of one storage cell, kept as a struct for the two-process style.
    typedef struct packed {
        logic bit_v;
    } cell_t;
endpackage

// File: rtl/qrf_bit_cell.sv
module qrf_bit_cell
    import qrf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld_en,
    input  logic d_in,
    output logic q_out
);
    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (rst) begin
            cell_d.bit_v = 1'b0;
        end else if (ld_en) begin
            cell_d.bit_v = d_in;
        end
    end

    // Falling-edge storage.
    always_ff @(negedge clk) begin
        cell_q <= cell_d;
    end

    assign q_out = cell_q.bit_v;
endmodule

// File: rtl/qrf_word.sv
module qrf_word #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_cell
        qrf_bit_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .ld_en (ld_en),
            .d_in  (d_in[b]),
            .q_out (q_out[b])
        );
    end

    AST_WORD_LOAD: assert property (@(negedge clk) disable iff (rst)
        ld_en |=> (q_out == $past(d_in)));  // R2
    AST_WORD_HOLD: assert property (@(negedge clk) disable iff (rst)
        !ld_en |=> $stable(q_out));  // R3
endmodule

// File: rtl/qrf_wr_decode.sv
module qrf_wr_decode #(
    parameter int NUM   = 4,
    parameter int IDX_W = 2
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [NUM-1:0]   sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                sel[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/quad_regfile.sv
module quad_regfile #(
    parameter int DATA_W   = 4,
    parameter int NUM_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_idx,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int FLAT_W = DATA_W * NUM_REGS;

    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0]   word_q [NUM_REGS];
    logic [FLAT_W-1:0]   all_q;

    qrf_wr_decode #(.NUM(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .sel    (wr_sel)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        qrf_word #(.WIDTH(DATA_W)) u_word (
            .clk   (clk),
            .rst   (rst),
            .ld_en (wr_sel[r]),
            .d_in  (wr_data),
            .q_out (word_q[r])
        );
        assign all_q[r*DATA_W +: DATA_W] = word_q[r];
    end

    // Combinational read port.
    always_comb begin
        rd_data = word_q[rd_idx];
    end

    AST_ONE_WRITE: assert property (@(negedge clk) disable iff (rst)
        $onehot0(wr_sel));  // R4
    AST_WR_GATED: assert property (@(negedge clk) disable iff (rst)
        !wr_en |-> (wr_sel == '0));  // R3
    AST_RST_CLEAR: assert property (@(negedge clk)
        rst |=> (all_q == '0));  // R7
endmodule

// File: tb/quad_regfile_tb.sv
module quad_regfile_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_idx = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] rd_idx = '0;
    logic [3:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic [3:0] model [4];

    quad_regfile u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic [3:0] exp_read(input logic [1:0] idx);
        return model[idx];
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 4; i++) begin
            rd_idx = 2'(i);
            #1;
            check(req, rd_data, exp_read(2'(i)));
        end
    endtask

    // Drive one cycle; inputs are set between falling and rising edges.
    task automatic step(input logic r, input logic we, input logic [1:0] wi,
                        input logic [3:0] wd, input string req);
        rst = r; wr_en = we; wr_idx = wi; wr_data = wd;
        @(posedge clk); #2;
        rd_idx = wi; #1;
        check("R6 rising edge stores nothing", rd_data, exp_read(wi));
        @(negedge clk); #1;
        if (r) begin
            for (int i = 0; i < 4; i++) model[i] = 4'h0;
        end else if (we) begin
            model[wi] = wd;
        end
        read_all(req);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 4'h0;
        @(negedge clk); @(negedge clk); #1;
        read_all("R7 reset state");
        // R1 R2 R5: fill every word with a distinct value
        step(0, 1, 2'd0, 4'h3, "R2 write word0");
        step(0, 1, 2'd1, 4'hA, "R2 write word1");
        step(0, 1, 2'd2, 4'h5, "R4 write word2 others kept");
        step(0, 1, 2'd3, 4'hC, "R1 write word3");
        // R3: enable low, varied data and index
        step(0, 0, 2'd1, 4'hF, "R3 enable low holds");
        step(0, 0, 2'd3, 4'h0, "R3 enable low holds");
        // R8: back-to-back writes to one word
        step(0, 1, 2'd2, 4'h9, "R8 back to back first");
        step(0, 1, 2'd2, 4'h6, "R8 back to back last wins");
        // R5: read index changes alone
        rd_idx = 2'd1; #1; check("R5 combinational read", rd_data, 4'hA);
        rd_idx = 2'd3; #1; check("R5 combinational read", rd_data, 4'hC);
        // R7: reset together with a write
        step(1, 1, 2'd0, 4'hE, "R7 reset beats write");
        step(0, 1, 2'd0, 4'h7, "R2 write after reset");
        // random section
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 400; n++) begin
            logic r = ($urandom % 50) == 0;
            logic we = ($urandom % 4) != 0;
            step(r, we, 2'($urandom), 4'($urandom),
                 r ? "R7 random reset" : (we ? "R4 random write" : "R3 random hold"));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule